// File: doc/BRIEF.md
# Two-Wire Slave Address Matcher

This block listens to a two-wire serial bus as a slave and reports when a controller addresses this device. It watches already synchronized samples of the serial clock and data lines. A start condition is a falling data line while the clock is high, and a stop condition is a rising data line while the clock is high. After each start, the block shifts in data bits on clock rising edges, most significant bit first. It compares the first seven bits with a programmable own address, and it takes the eighth bit as the transfer direction.

The result is a single-cycle match pulse, which carries the direction bit with it. A separate single-cycle pulse marks a stop condition that ends a transfer the block has seen begin. The outputs are status pulses, not a stream, so they have no ready input and no back-pressure: a consumer must take each pulse in the cycle it is high. An address-enable input turns off matching without stopping the line tracking. A module enable clears all internal state and keeps every output quiet.

Top module: `tw_addr_match`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `en` low, `match_o`, `rw_o` and `stop_o` are 0. Dropping `en` discards any partly received frame and the bus-busy state.
- R2: A start condition arms the capture at bit 0. A start condition is `sda_i` going from 1 to 0 while `scl_i` is 1 in both the previous and the current sample.
- R3: Data bits are taken on `scl_i` rising edges, most significant first. The first bit after a start is compared with `own_addr[6]`, and the seventh bit with `own_addr[0]`.
- R4: When the eighth bit of a matching frame arrives, `match_o` is high for exactly one clock cycle. This happens two clock edges after the eighth rising edge appears on the inputs.
- R5: A match is reported only if all seven address bits equal `own_addr` and `addr_en` is 1. With `addr_en` at 0, no frame produces a match.
- R6: `rw_o` equals the eighth received bit (1 = read) in the cycle `match_o` is high, and it is 0 in every other cycle.
- R7: A start seen part-way through a frame drops the bits gathered so far and begins a new capture at bit 0.
- R8: Rising edges after the eighth bit are ignored until the next start, so they cause no further match pulse.
- R9: A stop condition is `sda_i` going from 0 to 1 while `scl_i` is 1 in both samples. It raises `stop_o` for one cycle only if a start has been seen since the last stop or enable. A stop on an idle bus gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable; low clears all state |
| scl_i | input | 1 | Synchronized serial clock sample |
| sda_i | input | 1 | Synchronized serial data sample |
| own_addr | input | ADDR_W (7) | Device address compared with received bits |
| addr_en | input | 1 | Allows a match to be declared |
| match_o | output | 1 | One-cycle pulse: address matched |
| rw_o | output | 1 | Direction bit, valid with `match_o` |
| stop_o | output | 1 | One-cycle pulse: stop ended a seen transfer |

## Verification
A corrupted bit counter or shift register shows up at the frame boundary. The match pulse then arrives for a wrong address, or it is missing or doubled. This is visible no later than two cycles after the eighth clock rising edge. A stale armed or busy flag shows up one frame later: as a match from bits that follow a full byte, or as a stop pulse on an idle bus. The bench sweeps every 7-bit address against several own-address values, so any wrongly ordered or wrongly compared bit position gives a missing or extra pulse within the same frame.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // Line events decoded from one pair of samples
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
  } bus_evt_t;
endpackage

// File: rtl/tw_line_watch.sv
module tw_line_watch
  import tw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);
  logic scl_q, sda_q;

  // Idle bus level is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    evt_o.start = en & scl_i & scl_q & sda_q & ~sda_i;
    evt_o.stop  = en & scl_i & scl_q & ~sda_q & sda_i;
    evt_o.rise  = en & scl_i & ~scl_q;
  end
endmodule

// File: rtl/tw_frame_shift.sv
module tw_frame_shift
  import tw_pkg::*;
#(
  parameter int FRAME_W = 8,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  bus_evt_t           evt_i,
  input  logic               sda_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               stop_seen_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               armed, busy;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      done_o  <= 1'b0;
      frame_o <= '0;
    end else if (!en) begin
      armed   <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (evt_i.start) begin
        armed <= 1'b1;
        busy  <= 1'b1;
        cnt   <= '0;
      end else if (evt_i.stop) begin
        armed <= 1'b0;
        busy  <= 1'b0;
        cnt   <= '0;
      end else if (evt_i.rise && armed) begin
        shreg <= {shreg[FRAME_W-3:0], sda_i};
        if (cnt == LAST) begin
          armed   <= 1'b0;
          cnt     <= '0;
          done_o  <= 1'b1;
          frame_o <= {shreg, sda_i};
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign stop_seen_o = evt_i.stop & busy;
  assign cnt_o       = cnt;
endmodule

// File: rtl/tw_addr_cmp.sv
module tw_addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              addr_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              done_i,
  input  logic [ADDR_W:0]   frame_i,
  input  logic              stop_seen_i,
  output logic              match_o,
  output logic              rw_o,
  output logic              stop_o
);
  logic [ADDR_W-1:0] eq;
  logic              hit;

  // Frame bit 0 is the direction; bits above it line up with the address
  for (genvar i = 0; i < ADDR_W; i++) begin : g_eq
    assign eq[i] = frame_i[i+1] ~^ own_addr[i];
  end

  assign hit = done_i & addr_en & (&eq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_o <= 1'b0;
      rw_o    <= 1'b0;
      stop_o  <= 1'b0;
    end else if (!en) begin
      match_o <= 1'b0;
      rw_o    <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      match_o <= hit;
      rw_o    <= hit & frame_i[0];
      stop_o  <= stop_seen_i;
    end
  end
endmodule

// File: rtl/tw_addr_match.sv
module tw_addr_match
  import tw_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_en,
  output logic              match_o,
  output logic              rw_o,
  output logic              stop_o
);
  localparam int FRAME_W = ADDR_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  bus_evt_t           evt;
  logic               done;
  logic [FRAME_W-1:0] frame;
  logic               stop_seen;
  logic [CNT_W-1:0]   cnt_w;

  tw_line_watch u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  tw_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .evt_i       (evt),
    .sda_i       (sda_i),
    .done_o      (done),
    .frame_o     (frame),
    .stop_seen_o (stop_seen),
    .cnt_o       (cnt_w)
  );

  tw_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .addr_en     (addr_en),
    .own_addr    (own_addr),
    .done_i      (done),
    .frame_i     (frame),
    .stop_seen_i (stop_seen),
    .match_o     (match_o),
    .rw_o        (rw_o),
    .stop_o      (stop_o)
  );
endmodule

// File: rtl/tw_addr_match_chk.sv
module tw_addr_match_chk #(
  parameter int FRAME_W = 8,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             addr_en,
  input logic             match_o,
  input logic             rw_o,
  input logic             stop_o,
  input logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  a_r1_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!match_o && !rw_o && !stop_o));

  a_r4_match_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);

  a_r5_no_match_unless_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(addr_en));

  a_r6_rw_only_with_match: assert property (@(posedge clk) disable iff (!rst_n)
    !match_o |-> !rw_o);

  a_r8_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);

  a_r9_stop_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o);
endmodule

bind tw_addr_match tw_addr_match_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .addr_en (addr_en),
  .match_o (match_o),
  .rw_o    (rw_o),
  .stop_o  (stop_o),
  .bit_cnt (cnt_w)
);

// File: tb/sim_tw_addr_match.sv
`timescale 1ns/1ps
module sim_tw_addr_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic [6:0] own = 7'h5A;
  logic       aen = 1'b1;
  logic       match_o, rw_o, stop_o;

  int checks = 0;
  int failures = 0;
  int n_match = 0;
  int n_stop = 0;
  int last_rw = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tw_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_i(scl), .sda_i(sda),
    .own_addr(own), .addr_en(aen),
    .match_o(match_o), .rw_o(rw_o), .stop_o(stop_o)
  );

  // Pulse counting away from the active edge
  always @(negedge clk) begin
    if (match_o) begin
      n_match = n_match + 1;
      last_rw = int'(rw_o);
    end
    if (stop_o) n_stop = n_stop + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic s_start();
    sda = 1'b1; wt(1);
    scl = 1'b1; wt(2);
    sda = 1'b0; wt(2);
    scl = 1'b0; wt(1);
  endtask

  task automatic s_bit(input bit b);
    sda = b;    wt(1);
    scl = 1'b1; wt(2);
    scl = 1'b0; wt(1);
  endtask

  task automatic s_stop();
    scl = 1'b0; sda = 1'b0; wt(1);
    scl = 1'b1; wt(2);
    sda = 1'b1; wt(3);
  endtask

  task automatic s_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) s_bit(v[i]);
  endtask

  // Sweep every received address against the current own address
  task automatic sweep();
    for (int a = 0; a < 128; a++) begin
      int m0, s0, exp_m;
      bit rw;
      rw = bit'(a[0] ^ a[3]);
      m0 = n_match; s0 = n_stop;
      s_start();
      s_byte({7'(a), rw});
      s_stop();
      exp_m = (aen && (7'(a) == own)) ? 1 : 0;
      chk((n_match - m0) == exp_m, "R3/R4/R5 match count", n_match - m0, exp_m);
      if (exp_m == 1) chk(last_rw == int'(rw), "R6 direction bit", last_rw, int'(rw));
      chk((n_stop - s0) == 1, "R9 stop after frame", n_stop - s0, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int m0, s0;
    wt(3);
    chk(match_o == 1'b0 && rw_o == 1'b0 && stop_o == 1'b0, "R1 reset outputs",
        int'({match_o, rw_o, stop_o}), 0);
    rst_n = 1'b1; wt(3);

    // R2 R3 R4 R5 R6 R9: exhaustive sweeps over several own addresses
    own = 7'h5A; aen = 1'b1; sweep();
    own = 7'h00; sweep();
    own = 7'h7F; sweep();
    own = 7'h33; aen = 1'b0; sweep();
    aen = 1'b1;

    // R7: repeated start in the middle of a byte
    own = 7'h4C;
    m0 = n_match;
    s_start();
    s_bit(1); s_bit(0); s_bit(0); s_bit(1);
    s_start();
    s_byte({7'h4C, 1'b1});
    wt(3);
    chk((n_match - m0) == 1, "R7 restart mid-byte", n_match - m0, 1);
    chk(last_rw == 1, "R6 rw after restart", last_rw, 1);
    s_stop();

    // R8: bits after the eighth ignored
    m0 = n_match;
    s_start();
    s_byte({7'h4C, 1'b0});
    s_byte({7'h4C, 1'b0});
    s_byte({7'h4C, 1'b1});
    s_stop();
    chk((n_match - m0) == 1, "R8 extra bits ignored", n_match - m0, 1);

    // R9: stop on idle bus gives no pulse
    s0 = n_stop;
    s_stop();
    chk((n_stop - s0) == 0, "R9 idle stop", n_stop - s0, 0);

    // R1: disabled, a matching frame is ignored
    en = 1'b0;
    m0 = n_match; s0 = n_stop;
    s_start(); s_byte({7'h4C, 1'b0}); s_stop();
    chk((n_match - m0) == 0, "R1 no match when disabled", n_match - m0, 0);
    chk((n_stop - s0) == 0, "R1 no stop when disabled", n_stop - s0, 0);

    // R1: disable mid-frame discards the capture
    en = 1'b1; wt(2);
    m0 = n_match; s0 = n_stop;
    s_start();
    s_bit(1); s_bit(0); s_bit(0);
    en = 1'b0; wt(1); en = 1'b1;
    s_bit(1); s_bit(1); s_bit(0); s_bit(0); s_bit(0);
    s_stop();
    chk((n_match - m0) == 0, "R1 disable drops frame", n_match - m0, 0);
    chk((n_stop - s0) == 0, "R1 disable clears busy", n_stop - s0, 0);

    // R2: recovered, a clean frame matches again
    m0 = n_match;
    s_start(); s_byte({7'h4C, 1'b0}); s_stop();
    chk((n_match - m0) == 1, "R2 start arms capture", n_match - m0, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule